// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block is a register-mapped timer peripheral with three independent channels. Each channel has a 32-bit down-counter, a 32-bit reload value and a small control register. The counter steps down once per prescaled tick. The tick rate comes from the peripheral clock divided by a power-of-four ratio that the control register selects. When a tick arrives while the count is zero, the counter reloads from the channel's reload value and a sticky underflow flag is set. Each channel drives a level interrupt whenever that flag and its enable are both high.

Software starts and stops the channels through one shared run register that has one bit per channel. Loading a reload value of zero turns a channel into a one-shot: after its first underflow it stays at zero. Access uses a simple synchronous bus. A write completes in the cycle it is presented. Read data is registered and can be taken one cycle after the read is presented.

Top module: `multi_timer`

## Requirements
- R1: Bytes are addressed and only word-aligned accesses (addr[1:0]==0) take effect. The run register sits at 0x00. Channel n occupies 0x04+12n (control), 0x08+12n (reload value) and 0x0C+12n (counter). Read data appears on bus_rdata in the cycle after a read is presented. Unmapped or misaligned reads return 0.
- R2: Bit n of the run register lets channel n count. While the bit is 0 the counter holds its value.
- R3: A running channel's counter decreases by one per tick. The tick period is 4 << (2*code) clocks, where code is control bits [2:0]. The first tick after the run bit is set lands one full period later, because the prescaler restarts from zero whenever the channel is stopped.
- R4: Control codes 4 to 7 divide by 256, the same as code 3.
- R5: A tick that arrives at count 0 loads the reload value into the counter and sets the underflow flag (control bit 8).
- R6: With a reload value of 0, the channel reaches 0 and then stays at 0, and the flag stays set.
- R7: Writing 0 to control bit 8 clears the flag. Writing 1 there leaves the flag unchanged. The select code (bits [2:0]) and the interrupt enable (bit 5) are written normally. All other control bits read as 0.
- R8: irq[n] is high exactly while channel n's flag and interrupt enable are both 1.
- R9: A counter write takes effect only while the channel is stopped. It is ignored while the channel runs.
- R10: After reset every register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The bench stops each channel after a chosen number of cycles and compares the frozen count with the number of ticks that should have elapsed. A prescaler that does not restart on stop, or that has an off-by-one period, leaves a different count. Reserved select codes are run long enough that decoding them raw or truncating them gives a visibly wrong count. Other directed cases check the following. A zero reload value must keep the channel pinned at zero. Writing 1 to the flag must neither set nor clear it. A counter write during a run must be dropped, so a design that accepts it reads back the new value. Randomized runs over all channels and codes also confirm that an idle channel keeps its count while another one runs.

// File: rtl/tmr_pkg.sv
// Shared constants for the multi-channel timer: control field positions,
// the register word layout and the prescaler counter width.
package tmr_pkg;
    localparam int SEL_W     = 3;   // select code width, bits [2:0]
    localparam int IE_BIT    = 5;   // interrupt enable position
    localparam int UF_BIT    = 8;   // sticky underflow flag position
    localparam int PS_W      = 8;   // prescaler counter, max ratio 256
    localparam int WORDS_PER = 3;   // control, reload, counter
    localparam int CH_WORD0  = 1;   // first channel word after run register
endpackage

// File: rtl/tmr_prescaler.sv
// Tick generator for one channel. It divides the clock by 4 << (2*code).
// Codes above 3 are treated as 3. It assumes run is a registered level.
// The divider restarts from zero while run is low.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] lim;
    logic [1:0]      code;

    // Saturate the code and form the terminal count
    always_comb begin
        code = (sel > 3'd3) ? 2'd3 : sel[1:0];
        lim  = PS_W'((32'd4 << {code, 1'b0}) - 32'd1);
        tick = run && (pcnt >= lim);
    end

    // Divider counter, cleared while stopped and on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (!run)   pcnt <= '0;
        else if (tick)   pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: down-counter, reload value, control fields and flag.
// It assumes the write strobes are one-hot and already decoded by the top.
// An underflow that sets the flag wins over a software clear in the same cycle.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ctrl_we,
    input  logic             const_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] constv,
    output logic [SEL_W-1:0] sel,
    output logic             ie,
    output logic             flag,
    output logic             irq
);
    logic tick;
    logic uf;

    tmr_prescaler u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (sel),
        .tick  (tick)
    );

    // Underflow is a tick that arrives while the count is zero
    always_comb uf = tick && (count == '0);

    // Level interrupt output
    always_comb irq = flag && ie;

    // Select code and interrupt enable fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            ie  <= 1'b0;
        end else if (ctrl_we) begin
            sel <= wdata[SEL_W-1:0];
            ie  <= wdata[IE_BIT];
        end
    end

    // Sticky flag: hardware sets it, a written 0 clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag <= 1'b0;
        else if (uf)                       flag <= 1'b1;
        else if (ctrl_we && !wdata[UF_BIT]) flag <= 1'b0;
    end

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)        constv <= '0;
        else if (const_we) constv <= wdata;
    end

    // Counter: step, reload on underflow, or load while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (uf)             count <= constv;
        else if (tick)           count <= count - 1'b1;
        else if (cnt_we && !run) count <= wdata;
    end
endmodule

// File: rtl/multi_timer.sv
// Top of the multi-channel timer. It decodes the synchronous register bus,
// holds the shared run register and registers the read data.
// It assumes ADDR_W is wide enough to cover all channel words.
module multi_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int WW = ADDR_W - 2;

    logic [WW-1:0]                word;
    logic                         aligned;
    logic                         wr_hit;
    logic [NUM_CH-1:0]            run_q;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_const;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0]            ch_flag;
    logic [CNT_W-1:0]             rd_mux;

    // Word index and alignment qualifier
    always_comb begin
        word    = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        wr_hit  = bus_sel && bus_wr && aligned;
    end

    // Shared run register
    always_ff @(posedge clk) begin
        if (!rst_n)                     run_q <= '0;
        else if (wr_hit && word == '0)  run_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int BW = CH_WORD0 + WORDS_PER * i;
        logic [SEL_W-1:0] sel_i;
        logic             ie_i;

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[i]),
            .ctrl_we  (wr_hit && word == WW'(BW)),
            .const_we (wr_hit && word == WW'(BW + 1)),
            .cnt_we   (wr_hit && word == WW'(BW + 2)),
            .wdata    (bus_wdata),
            .count    (ch_count[i]),
            .constv   (ch_const[i]),
            .sel      (sel_i),
            .ie       (ie_i),
            .flag     (ch_flag[i]),
            .irq      (irq[i])
        );

        // Control register view with unused bits reading zero
        always_comb begin
            ch_ctrl[i]             = '0;
            ch_ctrl[i][SEL_W-1:0]  = sel_i;
            ch_ctrl[i][IE_BIT]     = ie_i;
            ch_ctrl[i][UF_BIT]     = ch_flag[i];
        end
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            if (word == '0) rd_mux[NUM_CH-1:0] = run_q;
            for (int i = 0; i < NUM_CH; i++) begin
                if (word == WW'(CH_WORD0 + WORDS_PER * i))     rd_mux = ch_ctrl[i];
                if (word == WW'(CH_WORD0 + WORDS_PER * i + 1)) rd_mux = ch_const[i];
                if (word == WW'(CH_WORD0 + WORDS_PER * i + 2)) rd_mux = ch_count[i];
            end
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/multi_timer_chk.sv
// Property checker for the multi-channel timer. It is bound to the top and
// observes the run bits, counts, reload values and flags.
module multi_timer_chk #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_sel,
    input logic                         bus_wr,
    input logic [NUM_CH-1:0]            run,
    input logic [NUM_CH-1:0][CNT_W-1:0] count,
    input logic [NUM_CH-1:0][CNT_W-1:0] constv,
    input logic [NUM_CH-1:0]            flag
);
    logic bus_write;
    always_comb bus_write = bus_sel && bus_wr;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R2: a stopped channel with no bus write keeps its count
        a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(run[i]) && !$past(bus_write)) |-> $stable(count[i]));

        // R3: a running, nonzero counter only ever steps down by one
        a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run[i]) && !$past(bus_write) && $past(count[i]) != '0
             && count[i] != $past(count[i]))
            |-> count[i] == CNT_W'($past(count[i]) - 1));

        // R5: when the flag rises the counter has taken the reload value
        a_r5_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flag[i]) && !$past(bus_write)) |-> count[i] == constv[i]);

        // R7: the flag can only rise on a running channel, never from software
        a_r7_flag_from_hw_only: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(run[i]));
    end
endmodule

bind multi_timer multi_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .run     (run_q),
    .count   (ch_count),
    .constv  (ch_const),
    .flag    (ch_flag)
);

// File: tb/multi_timer_test.sv
// Self-checking bench: directed corner cases plus seeded random runs,
// compared against a bench-side model of each channel.
module multi_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int unsigned m_cnt [3];
    int unsigned m_const [3];
    bit          m_flag [3];
    bit          m_ie [3];
    int unsigned m_sel [3];

    multi_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic int unsigned divf(int unsigned s);
        return (s > 3) ? 256 : (4 << (2 * s));
    endfunction

    function automatic logic [5:0] a_ctrl(int ch);  return 6'(4 + 12 * ch);  endfunction
    function automatic logic [5:0] a_const(int ch); return 6'(8 + 12 * ch);  endfunction
    function automatic logic [5:0] a_cnt(int ch);   return 6'(12 + 12 * ch); endfunction

    function automatic logic [31:0] exp_ctrl(int ch);
        logic [31:0] v = '0;
        v[2:0] = 3'(m_sel[ch]);
        v[5]   = m_ie[ch];
        v[8]   = m_flag[ch];
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bw(logic [5:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic br(logic [5:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic model_ticks(int ch, int unsigned t);
        for (int unsigned k = 0; k < t; k++) begin
            if (m_cnt[ch] == 0) begin m_cnt[ch] = m_const[ch]; m_flag[ch] = 1; end
            else m_cnt[ch] = m_cnt[ch] - 1;
        end
    endtask

    task automatic set_ctrl(int ch, logic [31:0] v);
        bw(a_ctrl(ch), v);
        m_sel[ch] = v[2:0]; m_ie[ch] = v[5];
        if (!v[8]) m_flag[ch] = 0;
    endtask

    task automatic set_const(int ch, int unsigned v);
        bw(a_const(ch), v); m_const[ch] = v;
    endtask

    task automatic set_cnt(int ch, int unsigned v);
        bw(a_cnt(ch), v); m_cnt[ch] = v;
    endtask

    // Run channel ch for n idle cycles between start and stop writes
    task automatic run_for(int ch, int n);
        bw(6'h00, 32'(1 << ch));
        repeat (n) @(negedge clk);
        bw(6'h00, 32'h0);
        model_ticks(ch, (n + 1) / divf(m_sel[ch]));
    endtask

    task automatic check_ch(string req, int ch);
        logic [31:0] d;
        br(a_cnt(ch), d);  chk({req, " count"}, d, m_cnt[ch]);
        br(a_ctrl(ch), d); chk({req, " ctrl"}, d, exp_ctrl(ch));
        chk({req, " irq"}, 32'(irq[ch]), 32'(m_flag[ch] && m_ie[ch]));
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7741));
        for (int i = 0; i < 3; i++) begin
            m_cnt[i] = 0; m_const[i] = 0; m_flag[i] = 0; m_ie[i] = 0; m_sel[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10: reset values
        br(6'h00, d);      chk("R10 run reg", d, 0);
        br(a_ctrl(0), d);  chk("R10 ctrl0", d, 0);
        br(a_const(1), d); chk("R10 const1", d, 0);
        br(a_cnt(2), d);   chk("R10 cnt2", d, 0);
        chk("R10 irq", 32'(irq), 0);

        // R1: address map, unmapped and misaligned reads
        for (int i = 0; i < 3; i++) begin
            set_const(i, 32'h100 + i);
            set_cnt(i, 32'h200 + i);
        end
        for (int i = 0; i < 3; i++) begin
            br(a_const(i), d); chk("R1 const map", d, 32'h100 + i);
            br(a_cnt(i), d);   chk("R1 cnt map", d, 32'h200 + i);
        end
        br(6'h30, d); chk("R1 unmapped", d, 0);
        br(6'h0d, d); chk("R1 misaligned", d, 0);

        // R3: tick count at divide by 4, then prescaler restart on stop
        set_ctrl(0, 32'h020); set_const(0, 3); set_cnt(0, 5);
        run_for(0, 9);  check_ch("R3 div4", 0);
        run_for(0, 2);  check_ch("R3 prescaler restart", 0);

        // R5 R8: underflow reloads and raises the interrupt
        run_for(0, 15); check_ch("R5 R8 underflow", 0);

        // R7 R8: writing 1 keeps the flag, enable off drops irq
        set_ctrl(0, 32'h100); check_ch("R7 R8 write one keeps flag", 0);
        set_ctrl(0, 32'h020); check_ch("R7 flag cleared", 0);
        set_ctrl(0, 32'h121); check_ch("R7 write one cannot set", 0);
        set_ctrl(0, 32'hFFFF_FEDF);
        br(a_ctrl(0), d); chk("R7 unused bits zero", d, exp_ctrl(0));

        // R6: zero reload stays at zero
        set_ctrl(1, 32'h020); set_const(1, 0); set_cnt(1, 2);
        run_for(1, 40); check_ch("R6 zero reload", 1);

        // R9: counter write while running is dropped
        set_ctrl(2, 32'h003); set_cnt(2, 100);
        bw(6'h00, 32'h4);
        bw(a_cnt(2), 32'h7);
        bw(6'h00, 32'h0);
        br(a_cnt(2), d); chk("R9 write while running", d, 100);

        // R4: reserved code behaves as divide by 256
        set_ctrl(2, 32'h005); set_cnt(2, 10);
        run_for(2, 600); check_ch("R4 reserved code", 2);

        // R2: stopped channel holds its count
        repeat (300) @(negedge clk);
        br(a_cnt(2), d); chk("R2 frozen", d, m_cnt[2]);

        // Random runs across channels and codes
        for (int it = 0; it < 25; it++) begin
            int ch = int'($urandom_range(0, 2));
            int oc = (ch + 1) % 3;
            logic [31:0] cv = {23'h0, 1'b0, 2'b0, 1'($urandom_range(0, 1)), 2'b0,
                               3'($urandom_range(0, 7))};
            set_ctrl(ch, cv);
            set_const(ch, $urandom_range(0, 10));
            set_cnt(ch, $urandom_range(0, 20));
            run_for(ch, int'($urandom_range(0, 600)));
            check_ch("R3 R5 random", ch);
            br(a_cnt(oc), d); chk("R2 idle channel", d, m_cnt[oc]);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule